// File: doc/BRIEF.md
# Receive Lock Monitor with Reference Fallback

This block watches over a clock-recovery loop and decides whether the recovered clock can be trusted. It looks at two things. The first is the retimed bit stream, where it measures how long the line has stayed at one level. The second is the rate of recovered bit ticks, which it compares with a local reference tick over a fixed window. When the loop is healthy it raises a lock flag and leaves the recovered clock as the downstream source. When it sees a run of identical bits that is too long, or a rate error above the tolerance, it drops the flag and selects the reference as the clock source. This keeps downstream logic at the right frequency.

After a fallback the block waits in reference mode for a programmable number of reference ticks. It then starts tracking the data again. Lock is declared once two back-to-back measurement windows come out clean. A small rate disturbance, such as one slipped or extra tick caused by a phase step, stays inside the tolerance and never drops lock on its own. An active-low force input holds the block in reference mode for as long as it is low. All inputs are single-cycle strobes or levels that are already synchronous to `clk`.

Top module: `rx_lock_monitor`

## Requirements
- R1: While `rst_n` is low, and on the first cycle after it is released, `locked` is 0 and `ref_sel` is 0 (acquiring on the recovered clock).
- R2: A measurement window is 2^WIN_LOG2 reference ticks long. It is clean when the number of recovered ticks inside it differs from 2^WIN_LOG2 by at most FREQ_TOL. From acquisition, `locked` rises on the clock edge that closes the second consecutive clean window, and not earlier.
- R3: A run of exactly RUN_MAX identical valid bits leaves lock unchanged. The valid bit that makes the run RUN_MAX+1 long drops `locked` at the edge that samples it, and `ref_sel` rises at that same edge.
- R4: While locked, a window whose count error is greater than FREQ_TOL drops lock and selects the reference. This applies whether the recovered ticks are too few or too many.
- R5: A count error of FREQ_TOL or less in every window, including a single missing recovered tick from a phase step, never drops lock.
- R6: After a loss of lock, `ref_sel` stays 1 and `locked` stays 0 for HOLD_TICKS reference ticks. Then `ref_sel` returns to 0 with `locked` still 0, and acquisition per R2 starts again.
- R7: While `force_ref_n` is low, from the next edge on `ref_sel` is 1 and `locked` is 0, whatever the data does. After release, acquisition restarts with empty windows, so lock needs two full windows.
- R8: `locked` and `ref_sel` are never 1 at the same time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rx_bit | input | 1 | Retimed data bit, valid when `rx_bit_vld` is 1 |
| rx_bit_vld | input | 1 | Recovered-clock tick; one per received bit |
| ref_tick | input | 1 | Local reference tick at the nominal bit rate |
| force_ref_n | input | 1 | Active low: hold the block in reference mode |
| locked | output | 1 | Loop declared in lock |
| ref_sel | output | 1 | 1 selects the reference clock for downstream clocking, 0 the recovered clock |

## Verification
The hardest condition to reach from the ports is a window whose count error sits exactly at the tolerance. The window boundaries are internal and cannot be seen from outside. The bench therefore removes recovered or reference ticks with a period that divides the window length. Every window then holds a known number of missing ticks, whatever its alignment. A drop period of half the window gives an error equal to the tolerance. A period of a quarter window gives twice that. Run-length limits are reached by switching the data to a fixed level that is opposite to the last toggled bit, so the run length is known to the bit.

// File: rtl/rx_lock_pkg.sv
// Shared types for the receive lock monitor.
package rx_lock_pkg;

    // Supervisor states: acquiring, locked, timed fallback, forced reference.
    typedef enum logic [1:0] {
        ST_ACQ   = 2'd0,
        ST_LOCK  = 2'd1,
        ST_HOLD  = 2'd2,
        ST_FORCE = 2'd3
    } lk_state_e;

endpackage

// File: rtl/rx_lock_runlen.sv
// Run-length watcher.
// Counts consecutive identical valid bits and pulses run_viol for one cycle
// on the valid bit that makes the run RUN_MAX+1 bits long.
// Assumes: bit_vld is a single-cycle strobe per received bit.
module rx_lock_runlen #(
    parameter int RUN_MAX = 128
) (
    input  logic clk,
    input  logic rst_n,
    input  logic bit_in,
    input  logic bit_vld,
    output logic run_viol
);
    localparam int RW = $clog2(RUN_MAX + 2);

    logic          last_q;
    logic [RW-1:0] run_q;
    logic          same;

    // Bit continues the current run only if a run has started.
    assign same     = (run_q != '0) && (bit_in == last_q);
    assign run_viol = bit_vld && same && (run_q == RW'(RUN_MAX));

    // Track last bit and saturating run length; restart on every transition.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            last_q <= 1'b0;
            run_q  <= '0;
        end else if (bit_vld) begin
            last_q <= bit_in;
            if (!same)
                run_q <= RW'(1);
            else if (run_q != '1)
                run_q <= run_q + RW'(1);
        end
    end
endmodule

// File: rtl/rx_lock_freqwin.sv
// Frequency window comparator.
// Counts recovered ticks across 2^WIN_LOG2 reference ticks. At the closing
// reference tick it raises win_done, and win_bad when the count is off
// nominal by more than FREQ_TOL.
// Assumes: clr restarts an empty window; counts saturate on a stalled reference.
module rx_lock_freqwin #(
    parameter int WIN_LOG2 = 14,
    parameter int FREQ_TOL = 10
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic ref_tick,
    input  logic rec_tick,
    output logic win_done,
    output logic win_bad
);
    localparam int             CW  = WIN_LOG2 + 2;
    localparam logic [CW-1:0]  NOM = CW'(1) << WIN_LOG2;

    logic [WIN_LOG2-1:0] ref_q;
    logic [CW-1:0]       rec_q;
    logic [CW-1:0]       rec_nxt;
    logic [CW-1:0]       err;

    // Recovered count including this cycle's tick, saturating.
    assign rec_nxt  = (rec_tick && (rec_q != '1)) ? rec_q + CW'(1) : rec_q;
    assign win_done = ref_tick && (&ref_q) && !clr;

    // Absolute count error against the nominal window length.
    always_comb begin
        err     = (rec_nxt >= NOM) ? (rec_nxt - NOM) : (NOM - rec_nxt);
        win_bad = win_done && (err > CW'(FREQ_TOL));
    end

    // Advance both counters; empty the recovered count at each window close.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            ref_q <= '0;
            rec_q <= '0;
        end else begin
            if (ref_tick)
                ref_q <= ref_q + WIN_LOG2'(1);
            rec_q <= win_done ? '0 : rec_nxt;
        end
    end
endmodule

// File: rtl/rx_lock_fsm.sv
// Lock supervisor state machine.
// Declares lock after two consecutive clean windows. Drops to a timed
// reference hold on a run violation or a bad window, and returns to
// acquisition after HOLD_TICKS reference ticks. A low force input overrides.
// Assumes: force_ref_n is already synchronous to clk.
module rx_lock_fsm
    import rx_lock_pkg::*;
#(
    parameter int HOLD_TICKS = 250
) (
    input  logic clk,
    input  logic rst_n,
    input  logic force_ref_n,
    input  logic ref_tick,
    input  logic run_viol,
    input  logic win_done,
    input  logic win_bad,
    output logic locked,
    output logic ref_sel,
    output logic win_clr
);
    localparam int HW = $clog2(HOLD_TICKS + 1);

    lk_state_e     state_q, state_d;
    logic          good_q, good_d;
    logic [HW-1:0] hold_q, hold_d;
    logic          fault;

    assign fault = run_viol || (win_done && win_bad);

    // Next-state and counter logic; the force input takes priority.
    always_comb begin
        state_d = state_q;
        good_d  = good_q;
        hold_d  = hold_q;
        if (!force_ref_n) begin
            state_d = ST_FORCE;
            good_d  = 1'b0;
            hold_d  = '0;
        end else begin
            case (state_q)
                ST_FORCE: begin
                    state_d = ST_ACQ;
                    good_d  = 1'b0;
                end
                ST_ACQ: begin
                    if (fault)
                        good_d = 1'b0;
                    else if (win_done) begin
                        if (good_q) begin
                            state_d = ST_LOCK;
                            good_d  = 1'b0;
                        end else
                            good_d = 1'b1;
                    end
                end
                ST_LOCK: begin
                    if (fault) begin
                        state_d = ST_HOLD;
                        hold_d  = '0;
                    end
                end
                default: begin
                    if (ref_tick) begin
                        if (hold_q == HW'(HOLD_TICKS - 1)) begin
                            state_d = ST_ACQ;
                            hold_d  = '0;
                        end else
                            hold_d = hold_q + HW'(1);
                    end
                end
            endcase
        end
    end

    // State and counter registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_ACQ;
            good_q  <= 1'b0;
            hold_q  <= '0;
        end else begin
            state_q <= state_d;
            good_q  <= good_d;
            hold_q  <= hold_d;
        end
    end

    assign locked  = (state_q == ST_LOCK);
    assign ref_sel = (state_q == ST_HOLD) || (state_q == ST_FORCE);
    assign win_clr = (state_q == ST_HOLD) || (state_q == ST_FORCE);
endmodule

// File: rtl/rx_lock_monitor.sv
// Receive lock monitor with reference fallback (top).
// Combines the run-length watcher, the frequency window comparator and the
// supervisor. Outputs come straight from the supervisor's state register.
// Assumes: all inputs are synchronous to clk; ticks are single-cycle strobes.
module rx_lock_monitor #(
    parameter int RUN_MAX    = 128,
    parameter int WIN_LOG2   = 14,
    parameter int FREQ_TOL   = 10,
    parameter int HOLD_TICKS = 250
) (
    input  logic clk,
    input  logic rst_n,
    input  logic rx_bit,
    input  logic rx_bit_vld,
    input  logic ref_tick,
    input  logic force_ref_n,
    output logic locked,
    output logic ref_sel
);
    logic run_viol;
    logic win_done;
    logic win_bad;
    logic win_clr;

    rx_lock_runlen #(.RUN_MAX(RUN_MAX)) u_runlen (
        .clk      (clk),
        .rst_n    (rst_n),
        .bit_in   (rx_bit),
        .bit_vld  (rx_bit_vld),
        .run_viol (run_viol)
    );

    rx_lock_freqwin #(.WIN_LOG2(WIN_LOG2), .FREQ_TOL(FREQ_TOL)) u_freqwin (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (win_clr),
        .ref_tick (ref_tick),
        .rec_tick (rx_bit_vld),
        .win_done (win_done),
        .win_bad  (win_bad)
    );

    rx_lock_fsm #(.HOLD_TICKS(HOLD_TICKS)) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .force_ref_n (force_ref_n),
        .ref_tick    (ref_tick),
        .run_viol    (run_viol),
        .win_done    (win_done),
        .win_bad     (win_bad),
        .locked      (locked),
        .ref_sel     (ref_sel),
        .win_clr     (win_clr)
    );
endmodule

// File: rtl/rx_lock_monitor_chk.sv
// Property checker for rx_lock_monitor, attached with bind.
// Relates the outputs to the inner strobes of the watcher and comparator.
module rx_lock_monitor_chk (
    input logic clk,
    input logic rst_n,
    input logic force_ref_n,
    input logic locked,
    input logic ref_sel,
    input logic run_viol,
    input logic win_done,
    input logic win_bad
);
    // R8: the two outputs are mutually exclusive.
    assert_excl_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !(locked && ref_sel));

    // R7: a low force input puts the block in reference mode next cycle.
    assert_force_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !force_ref_n |=> (ref_sel && !locked));

    // R3: a run violation while locked drops lock next cycle.
    assert_run_drop_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (run_viol && locked) |=> !locked);

    // R4: a bad window while locked selects the reference next cycle.
    assert_freq_drop_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (locked && win_done && win_bad && force_ref_n) |=> ref_sel);

    // R2: lock only rises right after a clean window closed.
    assert_lock_rise_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(locked) |-> $past(win_done && !win_bad));

    // R6: leaving reference mode always lands in acquisition, not lock.
    assert_fallback_exit_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ref_sel) |-> !locked);
endmodule

bind rx_lock_monitor rx_lock_monitor_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .force_ref_n (force_ref_n),
    .locked      (locked),
    .ref_sel     (ref_sel),
    .run_viol    (run_viol),
    .win_done    (win_done),
    .win_bad     (win_bad)
);

// File: tb/rx_lock_monitor_bench.sv
// Directed bench for rx_lock_monitor: one task per scenario.
module rx_lock_monitor_bench;
    localparam int RUN  = 16;
    localparam int WL   = 6;
    localparam int TOL  = 2;
    localparam int HOLD = 20;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic rx_bit = 1'b0;
    logic rx_bit_vld = 1'b0;
    logic ref_tick = 1'b0;
    logic force_ref_n = 1'b1;
    logic locked;
    logic ref_sel;

    int checks = 0;
    int fails = 0;
    int gcyc = 0;
    int rec_drop = 0;
    int ref_drop = 0;
    bit hold_en = 1'b0;
    bit hold_val = 1'b0;
    bit tgl = 1'b0;
    bit seen_unlock = 1'b0;
    bit seen_sel = 1'b0;
    bit done = 1'b0;

    rx_lock_monitor #(.RUN_MAX(RUN), .WIN_LOG2(WL), .FREQ_TOL(TOL), .HOLD_TICKS(HOLD))
    u_rx_lock_monitor (
        .clk(clk), .rst_n(rst_n), .rx_bit(rx_bit), .rx_bit_vld(rx_bit_vld),
        .ref_tick(ref_tick), .force_ref_n(force_ref_n),
        .locked(locked), .ref_sel(ref_sel)
    );

    always #10 clk = ~clk;

    task automatic check(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d (t=%0t)", req, act, exp, $time);
        end
    endtask

    // Drive one cycle of stimulus, then wait to the next falling edge.
    task automatic step();
        gcyc++;
        ref_tick   = !(ref_drop != 0 && (gcyc % ref_drop) == 0);
        rx_bit_vld = !(rec_drop != 0 && (gcyc % rec_drop) == 0);
        if (rx_bit_vld) begin
            if (hold_en) rx_bit = hold_val;
            else begin tgl = ~tgl; rx_bit = tgl; end
        end
        @(negedge clk);
        if (!locked) seen_unlock = 1'b1;
        if (ref_sel) seen_sel = 1'b1;
    endtask

    task automatic steps(int n);
        for (int i = 0; i < n; i++) step();
    endtask

    task automatic clear_seen();
        seen_unlock = 1'b0;
        seen_sel = 1'b0;
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        check("R1 locked in reset", locked, 0);
        check("R1 ref_sel in reset", ref_sel, 0);
        rst_n = 1'b1;
        step();
        check("R1 locked after release", locked, 0);
        check("R1 ref_sel after release", ref_sel, 0);
    endtask

    task automatic t_acquire();
        steps(118);
        check("R2 no lock before second window", locked, 0);
        steps(10);
        check("R2 lock after two clean windows", locked, 1);
        check("R8 ref_sel low when locked", ref_sel, 0);
    endtask

    task automatic t_runlen();
        hold_val = ~tgl;
        hold_en = 1'b1;
        steps(RUN);
        check("R3 run of RUN_MAX keeps lock", locked, 1);
        step();
        check("R3 run of RUN_MAX+1 drops lock", locked, 0);
        check("R3 ref_sel on run violation", ref_sel, 1);
        steps(10);
        check("R6 still on reference mid-hold", ref_sel, 1);
        check("R6 unlocked mid-hold", locked, 0);
        hold_en = 1'b0;
        steps(15);
        check("R6 back to recovered clock after hold", ref_sel, 0);
        check("R6 acquiring, not locked, after hold", locked, 0);
        steps(150);
        check("R2 relock after run fallback", locked, 1);
    endtask

    task automatic t_freq(int rec_p, int ref_p, string tag);
        clear_seen();
        rec_drop = rec_p;
        ref_drop = ref_p;
        steps(200);
        check({"R4 lock lost, ", tag}, seen_unlock, 1);
        check({"R4 reference selected, ", tag}, seen_sel, 1);
        check("R4 no relock while rate is off", locked, 0);
        rec_drop = 0;
        ref_drop = 0;
        steps(400);
        check({"R2 relock after rate restored, ", tag}, locked, 1);
    endtask

    task automatic t_tolerance();
        clear_seen();
        rec_drop = 32;
        steps(320);
        rec_drop = 0;
        check("R5 error equal to tolerance keeps lock", seen_unlock, 0);
        check("R5 no fallback at tolerance", seen_sel, 0);
        // Single slipped tick as from a phase step.
        clear_seen();
        rec_drop = 1;
        step();
        rec_drop = 0;
        steps(200);
        check("R5 single slipped tick keeps lock", seen_unlock, 0);
        check("R5 locked after phase step", locked, 1);
    endtask

    task automatic t_force();
        force_ref_n = 1'b0;
        step();
        check("R7 forced unlock", locked, 0);
        check("R7 forced reference", ref_sel, 1);
        clear_seen();
        steps(150);
        check("R7 force holds reference with clean data", ref_sel, 1);
        check("R7 no lock while forced", locked, 0);
        force_ref_n = 1'b1;
        step();
        check("R7 release returns to recovered clock", ref_sel, 0);
        steps(119);
        check("R7 no lock before two fresh windows", locked, 0);
        steps(20);
        check("R7 lock after two fresh windows", locked, 1);
    endtask

    initial begin
        @(negedge clk);
        t_reset();
        t_acquire();
        t_runlen();
        t_freq(16, 0, "recovered slow");
        t_freq(0, 16, "reference slow");
        t_tolerance();
        t_force();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog all requirements actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule